// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link: a transfer clock pin, a serial output and a serial input. Software controls it through a small register bus with three locations: data, mode and status. The mode location selects the bit order, the clock source and, for the internal clock, the division ratio. Writing the data location loads the byte to send and starts a transfer. Reading the data location returns the shift register as it stands. After eight transfer clocks that value is the received byte.

With the internal clock source the block is the master. It drives the clock pin, produces exactly eight clock periods, stops with the clock high and releases the serial output. With the external clock source the pin is synchronized into the system clock domain and its edges are detected there. The block raises its interrupt after eight clocks but keeps shifting on every further edge. In both modes the output bit changes on a falling edge and the input bit is captured on a rising edge. The system clock must run at least eight times faster than an external transfer clock.

Top module: `sio_port`

## Requirements
- R1: After reset the clock pin output is high and not driven (sclk_oe=0), irq is 0, sout_oe is 1, and reads of the mode location (address 1) and the status location (address 2) return 0.
- R2: A write to the data location (address 0) loads the shift register, clears irq, presets the 3-bit transfer counter to 7 and sets the busy bit. With the internal source it also forces the transfer clock high. The status read layout is bit 0 irq, bits 3:1 counter, bit 4 busy.
- R3: Mode bits 1:0 select the internal transfer clock period as 8, 16, 32 or 64 system clocks (codes 0 to 3). irq is first seen exactly 8 periods after the edge that took the data write.
- R4: Mode bit 5 selects the bit order: 0 sends and receives least significant bit first, 1 sends and receives most significant bit first.
- R5: sout changes only after a falling transfer-clock edge. sin is captured, and the register shifts by one bit, on each rising edge.
- R6: When an internal-clock transfer completes, the counter reads 0, busy clears, the clock stays high, irq is set and sout_oe drops to 0. sout_oe stays 0 while the internal source is idle.
- R7: With the external source (mode bit 2 = 0), irq is set after the eighth rising edge. Further rising edges keep shifting sin into the register.
- R8: With the external source, a data write made while the synchronized clock pin is low loads the data but does not arm the counter. busy stays 0 and no irq follows.
- R9: irq is sticky. Writing the status location with bit 0 = 0 clears it, writing bit 0 = 1 leaves it unchanged, and a data write clears it.
- R10: A read of the data location returns the shift register. After a complete transfer this is the received byte in the selected bit order.
- R11: While busy is 1, a write to the mode location leaves the clock-source bit (bit 2) unchanged.
- R12: sclk_oe equals the clock-source bit: the block drives the clock pin only with the internal source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 mode, 2 status |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data, one cycle after the address |
| sclk_in | input | 1 | Transfer clock pin input |
| sclk_out | output | 1 | Transfer clock pin output value |
| sclk_oe | output | 1 | Transfer clock pin drive enable |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output value |
| sout_oe | output | 1 | Serial data output enable |
| irq | output | 1 | Sticky transfer-done interrupt request |

## Verification
The bench acts as a link partner in both clock modes. It counts system cycles from the data write to the interrupt at every divider code. An off-by-one counter, or a divider that ignores its select, therefore shows up as a wrong cycle count. It sends and receives in both bit orders and compares every bit seen on sout. This catches a reversed order or a shift done on the wrong clock edge. It also checks that the master parks the clock high and releases sout after exactly eight bits. In external mode it sends a ninth clock and expects the register to keep shifting. It writes data while the external clock is low and expects no transfer to be armed. It changes the clock-source bit during a transfer and expects the change to be refused. It writes the status location with both values of bit 0, which catches an interrupt flag that clears on the wrong value or never clears.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2
  } sio_reg_e;

  // mode location field positions
  localparam int MODE_DIV_LSB = 0;
  localparam int MODE_SRC_BIT = 2;
  localparam int MODE_ORD_BIT = 5;

  // status location: bit 0 irq, counter above it, busy above the counter
  localparam int STAT_IRQ_BIT = 0;
  localparam int STAT_CNT_LSB = 1;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int BASE_HALF = 4,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             sclk,
  output logic             rise_p,
  output logic             fall_p
);
  localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
  localparam int PH_W     = $clog2(MAX_HALF);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last;
  logic            term;

  assign last   = PH_W'((BASE_HALF << div_sel) - 1);
  assign term   = run && (phase == last);
  assign rise_p = term && !sclk;
  assign fall_p = term && sclk;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      phase <= '0;
      sclk  <= 1'b1;
    end else if (term) begin
      phase <= '0;
      sclk  <= ~sclk;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise_p,
  output logic fall_p
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign level  = chain[STAGES-1];
  assign rise_p = level && !prev;
  assign fall_p = !level && prev;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              arm,
  input  logic [DATA_W-1:0] load_val,
  input  logic              msb_first,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              sin,
  output logic [DATA_W-1:0] sreg,
  output logic              sout,
  output logic [CNT_W-1:0]  cnt,
  output logic              active,
  output logic              done_p
);
  logic              out_bit;
  logic [DATA_W-1:0] shifted;

  assign out_bit = msb_first ? sreg[DATA_W-1] : sreg[0];
  assign shifted = msb_first ? {sreg[DATA_W-2:0], sin} : {sin, sreg[DATA_W-1:1]};
  assign done_p  = rise_p && active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      sout   <= 1'b1;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sreg <= load_val;
      if (arm) begin
        cnt    <= CNT_W'(DATA_W - 1);
        active <= 1'b1;
      end
    end else begin
      if (fall_p) sout <= out_bit;
      if (rise_p) begin
        sreg <= shifted;
        if (active) begin
          if (cnt == '0) active <= 1'b0;
          else           cnt    <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BASE_HALF   = 4,
  parameter int DIV_SEL_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sin,
  output logic              sout,
  output logic              sout_oe,
  output logic              irq
);
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int STAT_ACT = STAT_CNT_LSB + CNT_W;

  logic                 data_wr, mode_wr, stat_wr;
  logic [DIV_SEL_W-1:0] mode_div;
  logic                 mode_src, mode_msb;
  logic                 ext_level, ext_rise, ext_fall;
  logic                 int_rise, int_fall;
  logic                 rise_p, fall_p;
  logic                 arm, active, done_p;
  logic [CNT_W-1:0]     cnt;
  logic [DATA_W-1:0]    sreg;
  logic [DATA_W-1:0]    rd_mode, rd_stat, rd_next;

  assign data_wr = bus_we && (bus_addr == REG_DATA);
  assign mode_wr = bus_we && (bus_addr == REG_MODE);
  assign stat_wr = bus_we && (bus_addr == REG_STAT);

  // mode register; the clock source only moves while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_div <= '0;
      mode_src <= 1'b0;
      mode_msb <= 1'b0;
    end else if (mode_wr) begin
      mode_div <= bus_wdata[MODE_DIV_LSB +: DIV_SEL_W];
      mode_msb <= bus_wdata[MODE_ORD_BIT];
      if (!active) mode_src <= bus_wdata[MODE_SRC_BIT];
    end
  end

  sio_clkgen #(.BASE_HALF(BASE_HALF), .SEL_W(DIV_SEL_W)) clkgen_i (
    .clk     (clk),
    .rst     (rst),
    .restart (data_wr),
    .run     (mode_src && active),
    .div_sel (mode_div),
    .sclk    (sclk_out),
    .rise_p  (int_rise),
    .fall_p  (int_fall)
  );

  sio_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .pin    (sclk_in),
    .level  (ext_level),
    .rise_p (ext_rise),
    .fall_p (ext_fall)
  );

  assign rise_p = mode_src ? int_rise : ext_rise;
  assign fall_p = mode_src ? int_fall : ext_fall;
  assign arm    = data_wr && (mode_src || ext_level);

  sio_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) shifter_i (
    .clk       (clk),
    .rst       (rst),
    .load      (data_wr),
    .arm       (arm),
    .load_val  (bus_wdata),
    .msb_first (mode_msb),
    .rise_p    (rise_p),
    .fall_p    (fall_p),
    .sin       (sin),
    .sreg      (sreg),
    .sout      (sout),
    .cnt       (cnt),
    .active    (active),
    .done_p    (done_p)
  );

  // sticky interrupt flag
  always_ff @(posedge clk) begin
    if (rst)                                irq <= 1'b0;
    else if (data_wr)                       irq <= 1'b0;
    else if (done_p)                        irq <= 1'b1;
    else if (stat_wr && !bus_wdata[STAT_IRQ_BIT]) irq <= 1'b0;
  end

  assign sclk_oe = mode_src;
  assign sout_oe = mode_src ? active : 1'b1;

  always_comb begin
    rd_mode = '0;
    rd_mode[MODE_DIV_LSB +: DIV_SEL_W] = mode_div;
    rd_mode[MODE_SRC_BIT] = mode_src;
    rd_mode[MODE_ORD_BIT] = mode_msb;
    rd_stat = '0;
    rd_stat[STAT_IRQ_BIT] = irq;
    rd_stat[STAT_CNT_LSB +: CNT_W] = cnt;
    rd_stat[STAT_ACT] = active;
    case (bus_addr)
      REG_DATA: rd_next = sreg;
      REG_MODE: rd_next = rd_mode;
      REG_STAT: rd_next = rd_stat;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_src,
  input logic          active,
  input logic          data_wr,
  input logic [CW-1:0] cnt,
  input logic          sclk_out,
  input logic          sout_oe,
  input logic          irq
);
  // R6
  idle_park_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_src && !active) |-> (sclk_out && !sout_oe));

  // R2
  load_preset_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && mode_src) |=> (cnt == CW'(2**CW - 1) && active && !irq && sclk_out));

  // R9
  irq_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (cnt == '0 && !active));

  // R11
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(mode_src));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(data_wr)) |->
      (cnt == $past(cnt) || cnt == CW'($past(cnt) - 1'b1)));
endmodule

bind sio_port sio_port_chk #(.CW(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode_src (mode_src),
  .active   (active),
  .data_wr  (data_wr),
  .cnt      (cnt),
  .sclk_out (sclk_out),
  .sout_oe  (sout_oe),
  .irq      (irq)
);

// File: tb/sio_port_tb_top.sv
module sio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sclk_in = 1'b1;
  logic       sclk_out, sclk_oe, sin, sout, sout_oe, irq;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  int unsigned seed_v;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sio_port dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sin(sin), .sout(sout),
    .sout_oe(sout_oe), .irq(irq)
  );

  function automatic logic [7:0] mode_word(input logic [1:0] sel, input logic src, input logic msb);
    return {2'b00, msb, 2'b00, src, sel};
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] r, input logic b, input logic msb);
    return msb ? {r[6:0], b} : {b, r[7:1]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic int_xfer(input logic [1:0] sel, input logic msb, input logic [7:0] tx, input logic [7:0] rx);
    int wc;
    int bitn;
    logic prev;
    logic [7:0] d;
    bus_write(2'd1, mode_word(sel, 1'b1, msb));
    bus_write(2'd0, tx);
    wc = cyc;
    prev = 1'b1;
    bitn = 0;
    while (bitn < 8) begin
      @(negedge clk);
      if (prev && !sclk_out) sin = msb ? rx[7-bitn] : rx[bitn];
      if (!prev && sclk_out) begin
        check("R4/R5 sout bit", sout, msb ? tx[7-bitn] : tx[bitn]);
        bitn++;
      end
      prev = sclk_out;
    end
    check("R3 irq set", irq, 1);
    check("R3 cycles to irq", cyc - wc, 64 << sel);
    check("R6 sout released", sout_oe, 0);
    repeat (20) @(negedge clk);
    check("R6 clock parked high", sclk_out, 1);
    bus_read(2'd2, d);
    check("R6 status after done", d, 8'h01);
    bus_read(2'd0, d);
    check("R10 received byte", d, rx);
  endtask

  task automatic ext_clock(input logic b);
    @(negedge clk);
    sclk_in = 1'b0;
    sin = b;
    repeat (10) @(negedge clk);
    sclk_in = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic ext_xfer(input logic msb, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] d;
    bus_write(2'd1, mode_word(2'd0, 1'b0, msb));
    check("R12 pin released", sclk_oe, 0);
    bus_write(2'd0, tx);
    bus_read(2'd2, d);
    check("R2 armed status", d, 8'h1E);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sclk_in = 1'b0;
      sin = msb ? rx[7-i] : rx[i];
      repeat (10) @(negedge clk);
      check("R5 ext sout bit", sout, msb ? tx[7-i] : tx[i]);
      sclk_in = 1'b1;
      repeat (10) @(negedge clk);
    end
    check("R7 irq after eight", irq, 1);
    bus_read(2'd0, d);
    check("R10 ext received", d, rx);
    ext_clock(1'b1);
    bus_read(2'd0, d);
    check("R7 keeps shifting", d, shift_in(rx, 1'b1, msb));
  endtask

  initial begin
    logic [7:0] d;
    seed_v = $urandom(32'h5eed);
    sin = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 sclk_out", sclk_out, 1);
    check("R1 sclk_oe", sclk_oe, 0);
    check("R1 irq", irq, 0);
    check("R1 sout_oe", sout_oe, 1);
    bus_read(2'd1, d); check("R1 mode", d, 0);
    bus_read(2'd2, d); check("R1 status", d, 0);

    // R12 internal source drives the pin
    bus_write(2'd1, mode_word(2'd0, 1'b1, 1'b0));
    check("R12 pin driven", sclk_oe, 1);
    check("R6 idle sout_oe", sout_oe, 0);

    int_xfer(2'd0, 1'b0, 8'hA5, 8'h3C);
    int_xfer(2'd3, 1'b1, 8'h81, 8'h7E);
    int_xfer(2'd1, 1'b1, 8'h00, 8'hFF);
    int_xfer(2'd2, 1'b0, 8'hFF, 8'h00);

    // R9 sticky flag handling
    bus_write(2'd2, 8'h01);
    check("R9 write one keeps", irq, 1);
    bus_write(2'd2, 8'h00);
    check("R9 write zero clears", irq, 0);

    // R2 / R11 during a slow transfer
    int_xfer(2'd0, 1'b0, 8'h11, 8'h22);
    bus_write(2'd1, mode_word(2'd3, 1'b1, 1'b0));
    bus_write(2'd0, 8'h5A);
    check("R2/R9 data write clears irq", irq, 0);
    check("R2 clock high after write", sclk_out, 1);
    bus_read(2'd2, d);
    check("R2 status after write", d, 8'h1E);
    bus_write(2'd1, mode_word(2'd3, 1'b0, 1'b0));
    bus_read(2'd1, d);
    check("R11 source held", d, mode_word(2'd3, 1'b1, 1'b0));
    while (!irq) @(negedge clk);

    // random internal transfers
    for (int k = 0; k < 12; k++) begin
      logic [31:0] r;
      r = $urandom();
      int_xfer(r[1:0] & {r[2], 1'b1}, r[3], r[15:8], r[23:16]);
    end

    // external clock mode
    ext_xfer(1'b0, 8'hC3, 8'h96);
    ext_xfer(1'b1, 8'h4B, 8'hE1);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] r;
      r = $urandom();
      ext_xfer(r[0], r[15:8], r[23:16]);
    end

    // R8 write while external clock low
    @(negedge clk);
    sclk_in = 1'b0;
    repeat (10) @(negedge clk);
    bus_write(2'd0, 8'h77);
    bus_read(2'd2, d);
    check("R8 not armed", d, 8'h00);
    sclk_in = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 8; i++) ext_clock(1'b0);
    check("R8 no irq", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule